// File: doc/BRIEF.md
# Watchdog and Reset Sequencer

This block produces the reset and clock-enable timing for a small microcontroller-style system. When power comes up it holds the CPU and module clocks off while the oscillator settles. It then pulls the reset pin low for a fixed interval and holds the internal reset for one more interval before the processor may start. A free-running prescale counter drives a watchdog counter. If software does not service the watchdog in time, the watchdog expires and sends the system through the same pin-low and release phases. Software services it by writing to one fixed bus address.

The block records the cause of the most recent reset in a three-bit cause register that software can read. The cause is power-on, watchdog expiry or an external low level on the reset pin. The reset pin is open-drain: the block only enables a pull-low driver, and it reads the pin level back to detect an external reset. A hold input stops the watchdog from advancing, for example during debug.

Top module: `sys_rst_ctrl`

## Requirements
- R1: While `por_n` is low, and for `POR_HOLD` clock cycles after it rises, `rst_int` is 1, `clk_en` is 0 and `rst_pin_oe_n` is 0 (pin pulled low).
- R2: Each reset sequence then has two further phases. First comes a pin phase of `PIN_LOW` cycles with `clk_en`=1, `rst_pin_oe_n`=0 and `rst_int`=1. Then comes a release phase of `POST_LOW` cycles with `rst_pin_oe_n`=1 and `rst_int` still 1. After that `rst_int` drops to 0 (run).
- R3: Power-on sets `rst_cause` to 3'b001 (bit 0 = power-on, bit 1 = watchdog, bit 2 = external). This takes effect at once when `por_n` goes low.
- R4: In run, if no service write occurs, the watchdog expires on clock edge number 2^(PS_W+WD_W) after run is entered. On expiry `rst_cause` becomes 3'b010 and the pin and release phases of R2 follow, with no clock-off phase.
- R5: A service write is `wr_en`=1 with `wr_addr`=`SVC_ADDR`; no data is involved. It clears the watchdog count. On that edge the prescaler takes its incremented value with bits `CLR_HI` down to `CLR_LO` forced to 0. So a service write on run edge s moves expiry to edge s + 2^(PS_W+WD_W) − (s mod 2^CLR_LO). No watchdog tick occurs sooner than 2^PS_W − 2^CLR_LO cycles after a service write.
- R6: A write to any other address, or `SVC_ADDR` presented with `wr_en`=0, does not service the watchdog and leaves the expiry time unchanged.
- R7: In run, a low level on `rst_pin_in` at a clock edge starts the pin and release phases and sets `rst_cause` to 3'b100.
- R8: While `wd_hold` is 1, the watchdog count does not advance, but the prescaler keeps running. Ticks that fall after `wd_hold` returns to 0 are counted again.
- R9: Each new reset event replaces the cause register, so exactly one cause bit is set at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | ADDR_W | Bus write address |
| wd_hold | input | 1 | Freezes the watchdog count while high |
| rst_pin_in | input | 1 | Level read back from the reset pin |
| rst_int | output | 1 | Internal reset, active high |
| clk_en | output | 1 | Clock enable for CPU and modules |
| rst_pin_oe_n | output | 1 | Reset pin pull-low enable, active low |
| rst_cause | output | 3 | Latched cause of the latest reset (one-hot) |

## Verification
The bench builds the block with a 16-cycle power-on hold and 4-cycle pin and release phases. It uses a 5-bit prescaler whose bits 4..2 clear on service, and a 3-bit watchdog. With these values the watchdog expires after only 256 edges, so the bench can step a service write across twelve consecutive edges and compare each resulting expiry with the closed-form offset. At this size it can also run a long held interval across several prescaler wraps and cover every reset cause, all within a few thousand cycles. Every phase boundary of every sequence is checked cycle by cycle.

// File: rtl/sys_rst_pkg.sv
package sys_rst_pkg;
   typedef enum logic [1:0] {
      SEQ_POR  = 2'd0,
      SEQ_PIN  = 2'd1,
      SEQ_POST = 2'd2,
      SEQ_RUN  = 2'd3
   } seq_state_t;

   localparam int CAUSE_W = 3;
   typedef logic [CAUSE_W-1:0] cause_t;

   localparam cause_t CAUSE_POR = 3'b001;
   localparam cause_t CAUSE_WDT = 3'b010;
   localparam cause_t CAUSE_EXT = 3'b100;
endpackage

// File: rtl/rst_prescaler.sv
module rst_prescaler #(
   parameter int PS_W   = 13,
   parameter int CLR_LO = 4,
   parameter int CLR_HI = 12
) (
   input  logic clk,
   input  logic por_n,
   input  logic run,
   input  logic svc,
   output logic tick
);
   logic [PS_W-1:0] ps_q;
   logic [PS_W-1:0] mid_mask;

   // bit mask of the range that a service write clears
   for (genvar b = 0; b < PS_W; b++) begin : g_mask
      if (b >= CLR_LO && b <= CLR_HI) begin : g_in
         assign mid_mask[b] = 1'b1;
      end else begin : g_out
         assign mid_mask[b] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)      ps_q <= '0;
      else if (!run)   ps_q <= '0;
      else if (svc)    ps_q <= (ps_q + 1'b1) & ~mid_mask;
      else             ps_q <= ps_q + 1'b1;
   end

   // carry out of the top bit
   assign tick = run && (&ps_q);
endmodule

// File: rtl/rst_watchdog.sv
module rst_watchdog #(
   parameter int WD_W = 6
) (
   input  logic            clk,
   input  logic            por_n,
   input  logic            run,
   input  logic            svc,
   input  logic            tick,
   input  logic            hold,
   output logic            bite,
   output logic [WD_W-1:0] count
);
   logic adv;
   assign adv = run && tick && !hold && !svc;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)      count <= '0;
      else if (!run)   count <= '0;
      else if (svc)    count <= '0;
      else if (adv)    count <= count + 1'b1;
   end

   assign bite = adv && (&count);
endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer
   import sys_rst_pkg::*;
#(
   parameter int POR_HOLD = 4096,
   parameter int PIN_LOW  = 32,
   parameter int POST_LOW = 32
) (
   input  logic   clk,
   input  logic   por_n,
   input  logic   wd_bite,
   input  logic   ext_req,
   output logic   run,
   output logic   rst_int,
   output logic   clk_en,
   output logic   pin_oe_n,
   output cause_t cause
);
   localparam int MAX_A = (POR_HOLD > PIN_LOW) ? POR_HOLD : PIN_LOW;
   localparam int MAX_L = (MAX_A > POST_LOW) ? MAX_A : POST_LOW;
   localparam int CNT_W = $clog2(MAX_L + 1);
   localparam logic [CNT_W-1:0] END_POR  = CNT_W'(POR_HOLD - 1);
   localparam logic [CNT_W-1:0] END_PIN  = CNT_W'(PIN_LOW - 1);
   localparam logic [CNT_W-1:0] END_POST = CNT_W'(POST_LOW - 1);

   seq_state_t       st_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         st_q  <= SEQ_POR;
         cnt_q <= '0;
         cause <= CAUSE_POR;
      end else begin
         case (st_q)
            SEQ_POR: begin
               if (cnt_q == END_POR) begin
                  st_q  <= SEQ_PIN;
                  cnt_q <= '0;
               end else cnt_q <= cnt_q + 1'b1;
            end
            SEQ_PIN: begin
               if (cnt_q == END_PIN) begin
                  st_q  <= SEQ_POST;
                  cnt_q <= '0;
               end else cnt_q <= cnt_q + 1'b1;
            end
            SEQ_POST: begin
               if (cnt_q == END_POST) begin
                  st_q  <= SEQ_RUN;
                  cnt_q <= '0;
               end else cnt_q <= cnt_q + 1'b1;
            end
            default: begin
               cnt_q <= '0;
               if (wd_bite) begin
                  st_q  <= SEQ_PIN;
                  cause <= CAUSE_WDT;
               end else if (ext_req) begin
                  st_q  <= SEQ_PIN;
                  cause <= CAUSE_EXT;
               end
            end
         endcase
      end
   end

   assign run      = (st_q == SEQ_RUN);
   assign rst_int  = (st_q != SEQ_RUN);
   assign clk_en   = (st_q != SEQ_POR);
   assign pin_oe_n = !((st_q == SEQ_POR) || (st_q == SEQ_PIN));
endmodule

// File: rtl/sys_rst_ctrl.sv
module sys_rst_ctrl
   import sys_rst_pkg::*;
#(
   parameter int                POR_HOLD = 4096,
   parameter int                PIN_LOW  = 32,
   parameter int                POST_LOW = 32,
   parameter int                PS_W     = 13,
   parameter int                CLR_LO   = 4,
   parameter int                CLR_HI   = 12,
   parameter int                WD_W     = 6,
   parameter int                ADDR_W   = 16,
   parameter logic [ADDR_W-1:0] SVC_ADDR = '1
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic              wd_hold,
   input  logic              rst_pin_in,
   output logic              rst_int,
   output logic              clk_en,
   output logic              rst_pin_oe_n,
   output logic [2:0]        rst_cause
);
   if (POR_HOLD < 1 || PIN_LOW < 1 || POST_LOW < 1) begin : g_bad_len
      $error("sys_rst_ctrl: phase lengths must be at least 1");
   end
   if (CLR_HI >= PS_W || CLR_LO > CLR_HI || CLR_LO < 0) begin : g_bad_clr
      $error("sys_rst_ctrl: clear range must lie inside the prescaler");
   end
   if (WD_W < 1 || ADDR_W < 1) begin : g_bad_w
      $error("sys_rst_ctrl: widths must be positive");
   end

   logic            run;
   logic            svc_hit;
   logic            ps_tick;
   logic            wd_bite;
   logic [WD_W-1:0] wd_cnt;
   cause_t          cause;

   assign svc_hit = run && wr_en && (wr_addr == SVC_ADDR);

   rst_prescaler #(.PS_W(PS_W), .CLR_LO(CLR_LO), .CLR_HI(CLR_HI)) u_ps (
      .clk(clk), .por_n(por_n), .run(run), .svc(svc_hit), .tick(ps_tick)
   );

   rst_watchdog #(.WD_W(WD_W)) u_wd (
      .clk(clk), .por_n(por_n), .run(run), .svc(svc_hit), .tick(ps_tick),
      .hold(wd_hold), .bite(wd_bite), .count(wd_cnt)
   );

   rst_sequencer #(.POR_HOLD(POR_HOLD), .PIN_LOW(PIN_LOW), .POST_LOW(POST_LOW)) u_seq (
      .clk(clk), .por_n(por_n), .wd_bite(wd_bite), .ext_req(!rst_pin_in),
      .run(run), .rst_int(rst_int), .clk_en(clk_en), .pin_oe_n(rst_pin_oe_n),
      .cause(cause)
   );

   assign rst_cause = cause;
endmodule

// File: rtl/sys_rst_ctrl_chk.sv
module sys_rst_ctrl_chk #(
   parameter int WD_W = 6
) (
   input logic            clk,
   input logic            por_n,
   input logic            wd_hold,
   input logic            rst_pin_in,
   input logic            rst_int,
   input logic            clk_en,
   input logic            rst_pin_oe_n,
   input logic [2:0]      rst_cause,
   input logic            run,
   input logic            svc_hit,
   input logic            wd_bite,
   input logic [WD_W-1:0] wd_cnt
);
   p_clk_off_r1: assert property (@(posedge clk) disable iff (!por_n)
      !clk_en |-> (rst_int && !rst_pin_oe_n));

   p_release_after_pin_r2: assert property (@(posedge clk) disable iff (!por_n)
      $fell(rst_int) |-> (rst_pin_oe_n && $past(rst_pin_oe_n)));

   p_bite_resets_r4: assert property (@(posedge clk) disable iff (!por_n)
      wd_bite |=> (rst_int && !rst_pin_oe_n && clk_en && rst_cause == 3'b010));

   p_svc_clears_r5: assert property (@(posedge clk) disable iff (!por_n)
      svc_hit |=> (wd_cnt == '0));

   p_ext_cause_r7: assert property (@(posedge clk) disable iff (!por_n)
      (run && !rst_pin_in && !wd_bite) |=> (rst_int && rst_cause == 3'b100));

   p_hold_freezes_r8: assert property (@(posedge clk) disable iff (!por_n)
      (run && wd_hold && !svc_hit && rst_pin_in) |=> (wd_cnt == $past(wd_cnt)));

   p_cause_onehot_r9: assert property (@(posedge clk) disable iff (!por_n)
      $countones(rst_cause) == 1);
endmodule

bind sys_rst_ctrl sys_rst_ctrl_chk #(.WD_W(WD_W)) u_chk (
   .clk(clk), .por_n(por_n), .wd_hold(wd_hold), .rst_pin_in(rst_pin_in),
   .rst_int(rst_int), .clk_en(clk_en), .rst_pin_oe_n(rst_pin_oe_n),
   .rst_cause(rst_cause), .run(run), .svc_hit(svc_hit), .wd_bite(wd_bite),
   .wd_cnt(wd_cnt)
);

// File: tb/sys_rst_ctrl_bench.sv
module sys_rst_ctrl_bench;
   localparam int HOLD = 16, PINL = 4, POSTL = 4, PSW = 5, CLO = 2, CHI = 4, WDW = 3;
   localparam int TMO  = 1 << (PSW + WDW);

   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_addr = 16'h0000;
   logic        wd_hold = 1'b0;
   logic        ext_pull = 1'b0;
   logic        pin_lvl;
   logic        rst_int, clk_en, rst_pin_oe_n;
   logic [2:0]  rst_cause;
   int          n_chk = 0;
   int          n_fail = 0;

   always #4 clk = ~clk;

   assign pin_lvl = (!rst_pin_oe_n || ext_pull) ? 1'b0 : 1'b1;

   sys_rst_ctrl #(
      .POR_HOLD(HOLD), .PIN_LOW(PINL), .POST_LOW(POSTL), .PS_W(PSW),
      .CLR_LO(CLO), .CLR_HI(CHI), .WD_W(WDW), .ADDR_W(16), .SVC_ADDR(16'hFFFF)
   ) u_sys_rst_ctrl (
      .clk(clk), .por_n(por_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wd_hold(wd_hold), .rst_pin_in(pin_lvl), .rst_int(rst_int),
      .clk_en(clk_en), .rst_pin_oe_n(rst_pin_oe_n), .rst_cause(rst_cause)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   // cycle-by-cycle check of a reset sequence starting at its first cycle
   task automatic check_seq(input int hold, input string req);
      for (int i = 0; i <= hold + PINL + POSTL; i++) begin
         chk({req, " rst_int"}, int'(rst_int), int'(i < hold + PINL + POSTL));
         chk({req, " clk_en"},  int'(clk_en),  int'(i >= hold));
         chk({req, " pin_oe_n"}, int'(rst_pin_oe_n), int'(i >= hold + PINL));
         if (i < hold + PINL + POSTL) step();
      end
   endtask

   // from run cycle 0, count edges until the internal reset rises
   task automatic run_to_timeout(input int svc_at, input logic we, input logic [15:0] ad,
                                 input int hold_until, output int n);
      n = 0;
      do begin
         wr_en   = (n + 1 == svc_at) ? we : 1'b0;
         wr_addr = ad;
         wd_hold = (n + 1 <= hold_until);
         step();
         n++;
      end while (!rst_int && n < 5000);
      wr_en = 1'b0;
      wd_hold = 1'b0;
   endtask

   initial begin
      int n;
      int bad;
      // R1 R3: held in power-on reset
      repeat (3) @(posedge clk);
      #2;
      chk("R1 rst_int during por", int'(rst_int), 1);
      chk("R1 clk_en during por", int'(clk_en), 0);
      chk("R1 pin during por", int'(rst_pin_oe_n), 0);
      chk("R3 cause at por", int'(rst_cause), 1);
      por_n = 1'b1;
      check_seq(HOLD, "R1 R2 power-on sequence");
      chk("R3 cause after por", int'(rst_cause), 1);

      // R4: unserviced expiry
      run_to_timeout(0, 1'b0, 16'hFFFF, 0, n);
      chk("R4 expiry edge", n, TMO);
      chk("R4 cause", int'(rst_cause), 2);
      check_seq(0, "R4 watchdog sequence");

      // R6: other addresses and missing strobe
      run_to_timeout(5, 1'b1, 16'hFFFE, 0, n);
      chk("R6 addr FFFE ignored", n, TMO);
      check_seq(0, "R6 seq");
      run_to_timeout(5, 1'b1, 16'h7FFF, 0, n);
      chk("R6 addr 7FFF ignored", n, TMO);
      check_seq(0, "R6 seq");
      run_to_timeout(5, 1'b0, 16'hFFFF, 0, n);
      chk("R6 no strobe ignored", n, TMO);
      check_seq(0, "R6 seq");

      // R5: sweep the service edge
      for (int s = 1; s <= 12; s++) begin
         run_to_timeout(s, 1'b1, 16'hFFFF, 0, n);
         chk("R5 serviced expiry", n, s + TMO - (s % (1 << CLO)));
         chk("R5 cause", int'(rst_cause), 2);
         check_seq(0, "R5 seq");
      end

      // R8: hold across 600 edges; ticks counted from edge 608 on
      run_to_timeout(0, 1'b0, 16'hFFFF, 600, n);
      chk("R8 held expiry", n, 608 + (WDW == 3 ? 7 : 0) * (1 << PSW));
      check_seq(0, "R8 seq");

      // R5: periodic service keeps the system running
      bad = 0;
      for (int c = 1; c <= 1100; c++) begin
         wr_en = (c % 200 == 0);
         wr_addr = 16'hFFFF;
         step();
         if (rst_int) bad = 1;
      end
      wr_en = 1'b0;
      chk("R5 periodic service no reset", bad, 0);

      // R7 R9: external reset replaces the watchdog cause
      ext_pull = 1'b1;
      step();
      ext_pull = 1'b0;
      chk("R7 ext cause", int'(rst_cause), 4);
      chk("R9 single cause bit", $countones(rst_cause), 1);
      check_seq(0, "R7 ext sequence");

      // R3: power-on during run
      por_n = 1'b0;
      #1;
      chk("R3 cause on new por", int'(rst_cause), 1);
      chk("R1 clk_en on new por", int'(clk_en), 0);
      step();
      por_n = 1'b1;
      check_seq(HOLD, "R1 R2 second power-on");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule